// File: doc/BRIEF.md
# Nybble-Serial Register Write Assembler

This block is the write front end that every expansion bank on a bank-switching bus shares. The bus carries only four data bits for each register write, so a full control byte arrives as two writes in a row. The block takes each qualifying write, places its nybble in the half of a byte register chosen by a steering toggle, and flips the toggle. When the second nybble lands, it raises a write strobe for the register named by that write's address code. The strobe lasts one cycle and appears while the assembled byte is already complete on its output.

A write qualifies only when the memory-mapped register enable is low and the top three address bits carry one of four implemented register codes. A write to the control-register code with data bit 1 set is a resynchronisation command. It returns the steering toggle to the low half from any state, loads nothing and raises no strobe. Software uses it to recover when a stray write has knocked the pairing out of step.

Top module: `nyb_wr_asm`

## Requirements
- R1: While rst_ni is low, byte_o is 0x00 and wr_strobe_o is 0. The first qualifying nybble after reset goes to the low half.
- R2: Qualifying nybbles fill the byte alternately. The first goes to byte_o[3:0] and the second to byte_o[7:4]. Each half is visible in the cycle after the clock edge that samples its write.
- R3: In the cycle after the edge that samples a second nybble, exactly one bit of wr_strobe_o is high for one cycle, and byte_o holds the complete byte. Bit mapping by addr_i: [0] = 3'b010, [1] = 3'b100, [2] = 3'b101, [3] = 3'b110 (the control register).
- R4: The strobe selects the register by the address code of the second nybble's write, even when the first nybble used another code.
- R5: A write with io_en_ni high changes neither byte_o nor the steering toggle and raises no strobe.
- R6: A write to address codes 3'b000, 3'b001, 3'b011 or 3'b111 changes neither byte_o nor the steering toggle and raises no strobe.
- R7: A qualifying write to code 3'b110 with nyb_i[1] set loads nothing, raises no strobe, and makes the next qualifying nybble go to the low half, whichever half was due.
- R8: With wr_i low, byte_o holds its value and no strobe is raised.
- R9: A write to code 3'b110 with nyb_i[1] clear is an ordinary nybble and is assembled like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, high for one cycle per bus write |
| io_en_ni | input | 1 | Memory-mapped register enable, active low |
| addr_i | input | 3 | Address bits 15 to 13 (register code) |
| nyb_i | input | 4 | Data bits 3 to 0 |
| byte_o | output | 8 | Assembled byte |
| wr_strobe_o | output | 4 | One-hot register write strobes |

## Verification
The assertions assume that each bus write shows up as exactly one cycle of wr_i, with addr_i, io_en_ni and nyb_i valid in that same cycle. Under that assumption, the cycle after any write follows directly from the write alone. The bench keeps to this by driving every write on the falling edge, holding it for a single cycle and then dropping wr_i. It also places ignored writes, resync commands and reset between the two halves of a pair, so the toggle state that each rule must preserve or clear is actually exercised.

// File: rtl/nyb_wr_asm_pkg.sv
package nyb_wr_asm_pkg;
  localparam int ADDR_W   = 3;
  localparam int NYB_W    = 4;
  localparam int N_REGS   = 4;
  localparam int BYTE_W   = 2 * NYB_W;
  localparam int RSYNC_BIT = 1;

  localparam logic [ADDR_W-1:0] CODE_SEL  = 3'b010;
  localparam logic [ADDR_W-1:0] CODE_BANK = 3'b100;
  localparam logic [ADDR_W-1:0] CODE_DSEL = 3'b101;
  localparam logic [ADDR_W-1:0] CODE_CTL  = 3'b110;

  // strobe index i is addressed by REG_CODES[i*ADDR_W +: ADDR_W]
  localparam logic [N_REGS*ADDR_W-1:0] REG_CODES = {CODE_CTL, CODE_DSEL, CODE_BANK, CODE_SEL};
  localparam int CTL_IDX = 3;
endpackage

// File: rtl/nyb_wr_decode.sv
module nyb_wr_decode
  import nyb_wr_asm_pkg::*;
(
  input  logic              wr_i,
  input  logic              io_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rsync_bit_i,
  output logic [N_REGS-1:0] hit_o,
  output logic              load_o,
  output logic              rsync_o
);
  logic              acc;
  logic [N_REGS-1:0] match;

  assign acc = wr_i & ~io_en_ni;

  for (genvar i = 0; i < N_REGS; i++) begin : g_match
    assign match[i] = (addr_i == REG_CODES[i*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    hit_o   = acc ? match : '0;
    rsync_o = hit_o[CTL_IDX] & rsync_bit_i;
    load_o  = (|hit_o) & ~rsync_o;
  end
endmodule

// File: rtl/nyb_wr_steer.sv
module nyb_wr_steer
  import nyb_wr_asm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rsync_i,
  input  logic [NYB_W-1:0]  nyb_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              pair_done_o
);
  logic hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= 1'b0;
    else if (rsync_i) hi_q <= 1'b0;
    else if (load_i)  hi_q <= ~hi_q;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [NYB_W-1:0] half_q;
    logic             sel;
    assign sel = load_i & (hi_q == h[0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  half_q <= '0;
      else if (sel) half_q <= nyb_i;
    end
    assign byte_o[h*NYB_W +: NYB_W] = half_q;
  end

  assign pair_done_o = load_i & hi_q;
endmodule

// File: rtl/nyb_wr_strobe.sv
module nyb_wr_strobe
  import nyb_wr_asm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [N_REGS-1:0] hit_i,
  output logic [N_REGS-1:0] strobe_o
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_stb
    logic stb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_q <= 1'b0;
      else         stb_q <= fire_i & hit_i[i];
    end
    assign strobe_o[i] = stb_q;
  end
endmodule

// File: rtl/nyb_wr_asm.sv
module nyb_wr_asm
  import nyb_wr_asm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              io_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NYB_W-1:0]  nyb_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [N_REGS-1:0] wr_strobe_o
);
  logic [N_REGS-1:0] hit;
  logic              load, rsync, pair_done;

  nyb_wr_decode u_dec (
    .wr_i        (wr_i),
    .io_en_ni    (io_en_ni),
    .addr_i      (addr_i),
    .rsync_bit_i (nyb_i[RSYNC_BIT]),
    .hit_o       (hit),
    .load_o      (load),
    .rsync_o     (rsync)
  );

  nyb_wr_steer u_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .rsync_i     (rsync),
    .nyb_i       (nyb_i),
    .byte_o      (byte_o),
    .pair_done_o (pair_done)
  );

  nyb_wr_strobe u_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (pair_done),
    .hit_i    (hit),
    .strobe_o (wr_strobe_o)
  );
endmodule

// File: rtl/nyb_wr_asm_chk.sv
module nyb_wr_asm_chk
  import nyb_wr_asm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic              io_en_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rsync_bit_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic [N_REGS-1:0] wr_strobe_o
);
  logic acc, bad_code;
  assign acc      = wr_i & ~io_en_ni;
  assign bad_code = (addr_i == 3'b000) || (addr_i == 3'b001) ||
                    (addr_i == 3'b011) || (addr_i == 3'b111);

  AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_strobe_o)); // R3
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strobe_o) |=> (wr_strobe_o == '0)); // R3
  AST_IO_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && io_en_ni) |=> (wr_strobe_o == '0) && $stable(byte_o)); // R5
  AST_BAD_CODE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && bad_code) |=> (wr_strobe_o == '0) && $stable(byte_o)); // R6
  AST_RSYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && addr_i == CODE_CTL && rsync_bit_i) |=> (wr_strobe_o == '0) && $stable(byte_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (wr_strobe_o == '0) && $stable(byte_o)); // R8
endmodule

bind nyb_wr_asm nyb_wr_asm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .io_en_ni    (io_en_ni),
  .addr_i      (addr_i),
  .rsync_bit_i (nyb_i[1]),
  .byte_o      (byte_o),
  .wr_strobe_o (wr_strobe_o)
);

// File: tb/nyb_wr_asm_tb.sv
module nyb_wr_asm_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic       io_en_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [3:0] nyb_i = '0;
  logic [7:0] byte_o;
  logic [3:0] wr_strobe_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] m_byte = '0;
  logic       m_hi = 1'b0;
  logic [3:0] m_stb = '0;

  always #5 clk_i = ~clk_i;

  nyb_wr_asm dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .io_en_ni(io_en_ni),
    .addr_i(addr_i), .nyb_i(nyb_i), .byte_o(byte_o), .wr_strobe_o(wr_strobe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_bit(input logic [2:0] c);
    case (c)
      3'b010:  return 4'b0001;
      3'b100:  return 4'b0010;
      3'b101:  return 4'b0100;
      3'b110:  return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  // one bus write; model follows the requirements; checks byte and strobe after
  task automatic bus_wr(input string req, input logic [2:0] code, input logic [3:0] n,
                        input logic io_off);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = code; nyb_i = n; io_en_ni = io_off;
    m_stb = '0;
    if (!io_off && code_bit(code) != 0) begin
      if (code == 3'b110 && n[1]) m_hi = 1'b0;
      else if (!m_hi) begin m_byte[3:0] = n; m_hi = 1'b1; end
      else begin m_byte[7:4] = n; m_hi = 1'b0; m_stb = code_bit(code); end
    end
    @(negedge clk_i);
    wr_i = 1'b0; io_en_ni = 1'b1;
    chk(req, {24'h0, byte_o}, {24'h0, m_byte});
    chk(req, {28'h0, wr_strobe_o}, {28'h0, m_stb});
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk_i);
    chk(req, {28'h0, wr_strobe_o}, 32'h0);
    chk(req, {24'h0, byte_o}, {24'h0, m_byte});
  endtask

  task automatic t_reset;
    chk("R1 reset byte", {24'h0, byte_o}, 32'h0);
    chk("R1 reset strobe", {28'h0, wr_strobe_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    bus_wr("R1 first nybble low", 3'b010, 4'h5, 1'b0);
    bus_wr("R2 R3 second nybble high", 3'b010, 4'hA, 1'b0);
    idle_chk("R3 strobe one cycle");
    chk("R3 byte A5", {24'h0, byte_o}, 32'hA5);
  endtask

  task automatic t_mixed_codes;
    bus_wr("R2 low via 80", 3'b100, 4'h1, 1'b0);
    bus_wr("R4 R9 high via ctl bit1 clear", 3'b110, 4'h4, 1'b0);
    chk("R4 ctl strobe", {28'h0, wr_strobe_o}, 32'h8);
    idle_chk("R8 idle after strobe");
    bus_wr("R2 low via A0", 3'b101, 4'hE, 1'b0);
    bus_wr("R4 high via 80", 3'b100, 4'h7, 1'b0);
    chk("R4 bank strobe", {28'h0, wr_strobe_o}, 32'h2);
  endtask

  task automatic t_io_off;
    bus_wr("R5 low", 3'b101, 4'h3, 1'b0);
    bus_wr("R5 io off ignored", 3'b101, 4'hF, 1'b1);
    bus_wr("R5 io off ignored ctl", 3'b110, 4'h2, 1'b1);
    bus_wr("R5 pair kept", 3'b101, 4'h6, 1'b0);
    chk("R5 dsel strobe", {28'h0, wr_strobe_o}, 32'h4);
  endtask

  task automatic t_bad_codes;
    bus_wr("R6 low", 3'b100, 4'h7, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == 0 || i == 1 || i == 3 || i == 7)
        bus_wr("R6 unused code ignored", 3'(i), 4'h9, 1'b0);
    end
    bus_wr("R6 pair kept", 3'b100, 4'h2, 1'b0);
    chk("R6 byte 27", {24'h0, byte_o}, 32'h27);
  endtask

  task automatic t_rsync;
    bus_wr("R7 out of step low", 3'b010, 4'h8, 1'b0);
    bus_wr("R7 resync mid pair", 3'b110, 4'h2, 1'b0);
    bus_wr("R7 after resync low", 3'b010, 4'h1, 1'b0);
    chk("R7 low half 1", {28'h0, byte_o[3:0]}, 32'h1);
    bus_wr("R7 then high", 3'b010, 4'hC, 1'b0);
    chk("R7 byte C1", {24'h0, byte_o}, 32'hC1);
    bus_wr("R7 resync in step", 3'b110, 4'hF, 1'b0);
    bus_wr("R7 low after aligned resync", 3'b101, 4'h0, 1'b0);
    bus_wr("R7 high after aligned resync", 3'b101, 4'hD, 1'b0);
  endtask

  task automatic t_mid_reset;
    bus_wr("R1 before reset", 3'b010, 4'h6, 1'b0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    m_byte = '0; m_hi = 1'b0;
    chk("R1 async reset byte", {24'h0, byte_o}, 32'h0);
    chk("R1 async reset strobe", {28'h0, wr_strobe_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    bus_wr("R1 low after reset", 3'b100, 4'hB, 1'b0);
    bus_wr("R1 high after reset", 3'b100, 4'h3, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_mixed_codes();
    t_io_off();
    t_bad_codes();
    t_rsync();
    t_mid_reset();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule